// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits beside a small processor core and chooses which of sixteen interrupt sources is served next. Each source raises a request line. The block holds that request in a pending flag until the core accepts it. An individual enable bit gates each source. The ordinary sources also need the global interrupt enable to be set. The top two slots form a separate class. Slot 14 is non-maskable, so it ignores the global enable. Slot 15 is the reset slot, and it ignores both enable bits.

While any source qualifies, the block raises its request to the core. It also shows the winning slot and that slot's vector address. The vector slots are packed at the top of a 16-bit address space, one word per slot. When the core acknowledges, the block clears the winner's pending flag. It then saves the global enable on a small internal stack and forces the enable low, as the status-word push on interrupt entry would. A return-from-interrupt strobe pops the saved value back. Software inside a handler may set the global enable again, and the handler can then be interrupted by another source.

Top module: `vic_core`

## Requirements
- R1: After reset, no flag is pending, `gie_o` is 0 and `irq_o` is 0.
- R2: A single-cycle high on `req_i[i]` sets a pending flag for slot i. The flag shows on `irq_o` in the following cycle (when the slot qualifies) and stays set until slot i is acknowledged.
- R3: Slots 0 to 13 request service only when both their bit of `ien_i` and `gie_o` are 1.
- R4: Slot 14 needs its `ien_i` bit but ignores `gie_o`. Slot 15 requests service whenever it is pending, regardless of `ien_i` and `gie_o`.
- R5: Among the qualifying slots, the one with the highest index wins. `slot_o` gives the winner's index, and `vec_o` equals 0xFFE0 plus twice that index.
- R6: An `ack_i` pulse while `irq_o` is high clears the pending flag of the current winner only. In the next cycle, `irq_o` is high only if another qualifying slot is still pending.
- R7: An accepted acknowledge saves the current global enable and drives `gie_o` to 0 from the next cycle.
- R8: A `reti_i` pulse restores the most recently saved global enable, last in first out, for up to `SAVE_DEPTH` nested levels.
- R9: An `ack_i` pulse while `irq_o` is low, or a `reti_i` pulse with nothing saved, leaves `gie_o` unchanged.
- R10: `gie_wr_i` loads `gie_wdata_i` into the global enable in the next cycle. In the same cycle, an accepted acknowledge takes precedence over a return strobe, and a return strobe takes precedence over a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 16 | Per-slot request lines, which set the pending flags |
| ien_i | input | 16 | Per-slot enable bits |
| gie_wr_i | input | 1 | Software write strobe for the global enable |
| gie_wdata_i | input | 1 | Value written to the global enable |
| ack_i | input | 1 | Acknowledge pulse from the core |
| reti_i | input | 1 | Return-from-interrupt strobe |
| irq_o | output | 1 | Request to the core |
| vec_o | output | 16 | Vector address of the winning slot |
| slot_o | output | 4 | Index of the winning slot |
| gie_o | output | 1 | Current global enable |

## Verification
The assertions check four things on every cycle:
- the winning slot and the global enable stay consistent, so no maskable slot wins while the enable is clear;
- an accepted acknowledge always clears the enable;
- an ignored acknowledge leaves the enable untouched;
- a reset-slot request always wins in the next cycle.

Other behaviours need a run of events, so only the bench's scenarios can show them:
- the last-in-first-out order of restored enables across nested handlers;
- the pending flag persisting after its request has dropped;
- the exact vector values under mixed request patterns.

// File: rtl/vic_core.sv
module vic_core #(
  parameter int          N_SRC      = 16,
  parameter logic [15:0] VEC_BASE   = 16'hFFE0,
  parameter int          SAVE_DEPTH = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_SRC-1:0]         req_i,
  input  logic [N_SRC-1:0]         ien_i,
  input  logic                     gie_wr_i,
  input  logic                     gie_wdata_i,
  input  logic                     ack_i,
  input  logic                     reti_i,
  output logic                     irq_o,
  output logic [15:0]              vec_o,
  output logic [$clog2(N_SRC)-1:0] slot_o,
  output logic                     gie_o
);
  localparam int SW       = $clog2(N_SRC);
  localparam int CW       = $clog2(SAVE_DEPTH + 1);
  localparam int RST_SLOT = N_SRC - 1;
  localparam int NMI_SLOT = N_SRC - 2;

  logic [N_SRC-1:0]      pend_q, elig, win_oh;
  logic [SW-1:0]         win;
  logic                  gie_q, take, give;
  logic [SAVE_DEPTH-1:0] save_q;
  logic [CW-1:0]         depth_q;

  for (genvar i = 0; i < N_SRC; i++) begin : g_elig
    if (i == RST_SLOT) begin : g_rst
      assign elig[i] = pend_q[i];
    end else if (i == NMI_SLOT) begin : g_nmi
      assign elig[i] = pend_q[i] & ien_i[i];
    end else begin : g_mask
      assign elig[i] = pend_q[i] & ien_i[i] & gie_q;
    end
  end

  always_comb begin
    win = '0;
    for (int i = 0; i < N_SRC; i++)
      if (elig[i]) win = SW'(i);
  end

  assign irq_o  = |elig;
  assign slot_o = win;
  assign vec_o  = VEC_BASE + (16'(win) << 1);
  assign gie_o  = gie_q;

  assign take   = ack_i & irq_o;
  assign give   = reti_i & ~take & (depth_q != '0);
  assign win_oh = take ? (N_SRC'(1) << win) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      gie_q   <= 1'b0;
      save_q  <= '0;
      depth_q <= '0;
    end else begin
      pend_q <= (pend_q & ~win_oh) | req_i;
      if (take) begin
        gie_q   <= 1'b0;
        save_q  <= {save_q[SAVE_DEPTH-2:0], gie_q};
        depth_q <= (depth_q == CW'(SAVE_DEPTH)) ? depth_q : depth_q + 1'b1;
      end else if (give) begin
        gie_q   <= save_q[0];
        save_q  <= {1'b0, save_q[SAVE_DEPTH-1:1]};
        depth_q <= depth_q - 1'b1;
      end else if (gie_wr_i) begin
        gie_q <= gie_wdata_i;
      end
    end
  end
endmodule

// File: rtl/vic_core_chk.sv
module vic_core_chk #(
  parameter int N_SRC = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [N_SRC-1:0]         req_i,
  input logic                     gie_wr_i,
  input logic                     ack_i,
  input logic                     reti_i,
  input logic                     irq_o,
  input logic [$clog2(N_SRC)-1:0] slot_o,
  input logic                     gie_o
);
  localparam int SW = $clog2(N_SRC);

  p_mask_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !gie_o) |-> (slot_o >= SW'(N_SRC - 2)));

  p_rst_slot_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_i[N_SRC-1] |=> (irq_o && slot_o == SW'(N_SRC - 1)));

  p_ack_clears_gie_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o) |=> !gie_o);

  p_idle_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !irq_o && !reti_i && !gie_wr_i) |=> $stable(gie_o));
endmodule

bind vic_core vic_core_chk #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .gie_wr_i(gie_wr_i),
  .ack_i(ack_i), .reti_i(reti_i), .irq_o(irq_o), .slot_o(slot_o), .gie_o(gie_o)
);

// File: tb/vic_core_tb.sv
module vic_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] req = '0, ien = '0;
  logic        gie_wr = 1'b0, gie_wd = 1'b0, ack = 1'b0, reti = 1'b0;
  logic        irq, gie;
  logic [15:0] vec;
  logic [3:0]  slot;
  int          checks = 0, fails = 0;

  always #5 clk = ~clk;

  vic_core u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .ien_i(ien),
    .gie_wr_i(gie_wr), .gie_wdata_i(gie_wd), .ack_i(ack), .reti_i(reti),
    .irq_o(irq), .vec_o(vec), .slot_o(slot), .gie_o(gie)
  );

  // {req, ien, gie, exp_irq, exp_slot}
  localparam logic [37:0] TBL [10] = '{
    {16'h0001, 16'hFFFF, 1'b1, 1'b1, 4'd0},
    {16'h0001, 16'hFFFF, 1'b0, 1'b0, 4'd0},
    {16'h0001, 16'hFFFE, 1'b1, 1'b0, 4'd0},
    {16'h4000, 16'h4000, 1'b0, 1'b1, 4'd14},
    {16'h4000, 16'h0000, 1'b1, 1'b0, 4'd0},
    {16'h8000, 16'h0000, 1'b0, 1'b1, 4'd15},
    {16'h0A50, 16'hFFFF, 1'b1, 1'b1, 4'd11},
    {16'h0A50, 16'hF7FF, 1'b1, 1'b1, 4'd9},
    {16'h3000, 16'hFFFF, 1'b0, 1'b0, 4'd0},
    {16'hC000, 16'hFFFF, 1'b0, 1'b1, 4'd15}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req = '0; ack = 1'b0; reti = 1'b0; gie_wr = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic write_gie(input logic v);
    gie_wr = 1'b1; gie_wd = v; tick(); gie_wr = 1'b0;
  endtask

  task automatic pulse_req(input logic [15:0] r);
    req = r; tick(); req = '0;
  endtask

  task automatic pulse_ack();
    ack = 1'b1; tick(); ack = 1'b0;
  endtask

  task automatic pulse_reti();
    reti = 1'b1; tick(); reti = 1'b0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    #1;
    chk("R1 irq after reset", 32'(irq), 0);
    chk("R1 gie after reset", 32'(gie), 0);
    rst_n = 1'b1;

    for (int k = 0; k < 10; k++) begin
      do_reset();
      ien = TBL[k][21:6];
      write_gie(TBL[k][5]);
      pulse_req(TBL[k][37:22]);
      chk($sformatf("R3/R4 entry %0d irq", k), 32'(irq), 32'(TBL[k][4]));
      if (TBL[k][4]) begin
        chk($sformatf("R5 entry %0d slot", k), 32'(slot), 32'(TBL[k][3:0]));
        chk($sformatf("R5 entry %0d vec", k), 32'(vec), 32'(16'hFFE0 + 2 * TBL[k][3:0]));
      end
    end

    // R2 persistence
    do_reset(); ien = 16'h0001; write_gie(1'b1);
    chk("R10 gie after write", 32'(gie), 1);
    pulse_req(16'h0001);
    repeat (3) tick();
    chk("R2 pending held", 32'(irq), 1);

    // R6/R7/R8/R9 entry, nesting, return
    do_reset(); ien = 16'hFFFF; write_gie(1'b1);
    pulse_req(16'h4028);
    chk("R5 nmi wins", 32'(slot), 14);
    pulse_ack();
    chk("R7 gie cleared", 32'(gie), 0);
    chk("R6 maskable held off", 32'(irq), 0);
    pulse_ack();
    chk("R9 idle ack gie", 32'(gie), 0);
    pulse_reti();
    chk("R8 gie restored", 32'(gie), 1);
    chk("R6 next slot", 32'(slot), 5);
    pulse_ack();
    write_gie(1'b1);
    chk("R8 nested request", 32'(irq), 1);
    chk("R8 nested slot", 32'(slot), 3);
    pulse_ack();
    chk("R6 none left", 32'(irq), 0);
    pulse_reti(); pulse_reti();
    chk("R8 two returns", 32'(gie), 1);
    pulse_reti();
    chk("R9 empty return", 32'(gie), 1);

    // R8 LIFO with distinct saved values
    do_reset(); ien = 16'hFFFF;
    pulse_req(16'h4000);
    pulse_ack();
    write_gie(1'b1);
    pulse_req(16'h0004);
    chk("R8 inner slot", 32'(slot), 2);
    pulse_ack();
    pulse_reti();
    chk("R8 inner restore", 32'(gie), 1);
    pulse_reti();
    chk("R8 outer restore", 32'(gie), 0);

    // R6 two unmaskable
    do_reset(); ien = 16'hFFFF;
    pulse_req(16'hC000);
    pulse_ack();
    chk("R6 second remains", 32'(irq), 1);
    chk("R6 second slot", 32'(slot), 14);
    pulse_ack();
    chk("R6 all served", 32'(irq), 0);

    // R10 precedence: ack beats write
    do_reset(); ien = 16'hFFFF; write_gie(1'b1);
    pulse_req(16'h0002);
    ack = 1'b1; gie_wr = 1'b1; gie_wd = 1'b1; tick(); ack = 1'b0; gie_wr = 1'b0;
    chk("R10 ack over write", 32'(gie), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule